// File: doc/BRIEF.md
# GPIO Port Pin-Mode Controller

This block controls one general-purpose I/O port of eight pins. Software programs it through a small register interface. Each cycle it takes an address, a write strobe and write data, and it returns read data combinationally. For every pin it produces three pad controls: the level to drive, an output enable, and a pull-up enable. It also brings the pad input levels into the clock domain through a two-stage synchronizer.

There are three registers: a mode register, a pin data register and a pull-control register. The mode register holds a 2-bit drive mode for each pin. The four modes are input, push-pull, open-drain and open-source. Open-drain drives the pad only to 0, and open-source drives it only to 1; other devices on the same wire can then share it with a resistor. The pull-control register is active-low: a 1 turns the pin's pull-up off. The port window has three word offsets: mode at 0x0, data at 0x4 and pull at 0x8. A larger decoder can place several such ports at a fixed stride.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While `rst_n` is low, and afterwards until a write, every pin is in input mode. The output data is 0, `pad_oe` and `pad_out` are all 0, `pad_pull_en` is all 1, and reads of the mode and pull registers return 0.
- R2: The mode register sits at offset 0x0. Pin i's mode is in bits [2i+1:2i]. A write takes bits [15:0], bits [31:16] always read as 0, and the register reads back what was written.
- R3: Mode 01 is push-pull. `pad_oe` is 1 and `pad_out` equals the pin's output data bit.
- R4: Mode 10 is open-drain. `pad_out` is 0, and `pad_oe` is the inverse of the output data bit, so the pin floats when the data bit is 1.
- R5: Mode 11 is open-source. `pad_out` is 1, and `pad_oe` equals the output data bit, so the pin floats when the data bit is 0.
- R6: Mode 00 is input. `pad_oe` and `pad_out` are 0 whatever the output data holds.
- R7: A write to offset 0x4 sets the output data from bits [7:0]. The pad outputs follow from the edge of the write. A read of 0x4 returns the pad levels in bits [7:0]: a level held on `pad_in` before a clock edge appears on `reg_rdata` after exactly two rising edges, never after one.
- R8: The pull register sits at offset 0x8 and takes bits [7:0]. A 1 at bit i clears `pad_pull_en[i]`, a 0 sets it, and the register reads back as written.
- R9: Bits above each register's field read as 0. A write to any other offset changes nothing, and a read of such an offset returns 0.
- R10: The output data bits are kept while a pin's mode changes. A pin moved from input to push-pull drives the value last written to the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 4 | Byte offset within the port window |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pad_in | input | 8 | Pad input levels, asynchronous |
| pad_out | output | 8 | Level to drive on each pad |
| pad_oe | output | 8 | Pad output enable, 1 = drive |
| pad_pull_en | output | 8 | Pad pull-up enable, 1 = pulled up |

## Verification
A wrong mode decode shows up at once: in the same cycle after the write edge, `pad_oe` or `pad_out` on that pin disagrees with the mode and data bit. A wrong synchronizer depth moves the pad level seen at offset 0x4 one edge early or late, so the bench reads after the first edge as well as after the second. A stuck or lost register bit shows up either on the next read-back or directly on the pad controls, because every stored bit reaches a port without further delay.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    PM_INPUT    = 2'b00,
    PM_PUSHPULL = 2'b01,
    PM_ODRAIN   = 2'b10,
    PM_OSOURCE  = 2'b11
  } pin_mode_e;

  localparam logic [3:0] OFS_MODE = 4'h0;
  localparam logic [3:0] OFS_DATA = 4'h4;
  localparam logic [3:0] OFS_PULL = 4'h8;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

  // checker: edges since reset, saturating at two
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  assert_sync_depth_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (sync_out == $past(async_in, 2)));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int PINS = 8,
  parameter int AW   = 4,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            we,
  input  logic [DW-1:0]   wdata,
  input  logic [PINS-1:0] pin_level,
  output logic [DW-1:0]   rdata,
  output logic [2*PINS-1:0] mode_vec,
  output logic [PINS-1:0] out_val,
  output logic [PINS-1:0] pull_dis
);
  localparam int MW = 2 * PINS;

  logic [MW-1:0]   mode_q;
  logic [PINS-1:0] data_q;
  logic [PINS-1:0] pull_q;
  logic            unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[DW-1:MW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      data_q <= '0;
      pull_q <= '0;
    end else if (we) begin
      case (addr)
        AW'(OFS_MODE): mode_q <= wdata[MW-1:0];
        AW'(OFS_DATA): data_q <= wdata[PINS-1:0];
        AW'(OFS_PULL): pull_q <= wdata[PINS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(OFS_MODE): rdata[MW-1:0]   = mode_q;
      AW'(OFS_DATA): rdata[PINS-1:0] = pin_level;
      AW'(OFS_PULL): rdata[PINS-1:0] = pull_q;
      default: ;
    endcase
  end

  assign mode_vec = mode_q;
  assign out_val  = data_q;
  assign pull_dis = pull_q;

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(OFS_MODE)) |-> (rdata[DW-1:MW] == '0));
  assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr != AW'(OFS_MODE) && addr != AW'(OFS_DATA) && addr != AW'(OFS_PULL))
      |=> ($stable(mode_q) && $stable(data_q) && $stable(pull_q)));
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_port_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic [2*PINS-1:0] mode_vec,
  input  logic [PINS-1:0]   out_val,
  input  logic [PINS-1:0]   pull_dis,
  output logic [PINS-1:0]   drv_level,
  output logic [PINS-1:0]   drv_en,
  output logic [PINS-1:0]   pull_en
);
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    pin_mode_e m;
    assign m = pin_mode_e'(mode_vec[2*i +: 2]);
    always_comb begin
      case (m)
        PM_PUSHPULL: begin drv_level[i] = out_val[i]; drv_en[i] = 1'b1;        end
        PM_ODRAIN:   begin drv_level[i] = 1'b0;       drv_en[i] = ~out_val[i]; end
        PM_OSOURCE:  begin drv_level[i] = 1'b1;       drv_en[i] = out_val[i];  end
        default:     begin drv_level[i] = 1'b0;       drv_en[i] = 1'b0;        end
      endcase
    end
    assign pull_en[i] = ~pull_dis[i];
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int PINS = 8,
  parameter int AW   = 4,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_we,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_pull_en
);
  localparam int MW = 2 * PINS;

  logic [PINS-1:0] pin_level;
  logic [MW-1:0]   mode_vec;
  logic [PINS-1:0] out_val;
  logic [PINS-1:0] pull_dis;

  gpio_in_sync #(.WIDTH(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pin_level)
  );

  gpio_port_regs #(.PINS(PINS), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
    .pin_level(pin_level), .rdata(reg_rdata), .mode_vec(mode_vec),
    .out_val(out_val), .pull_dis(pull_dis)
  );

  gpio_pad_drive #(.PINS(PINS)) u_drive (
    .mode_vec(mode_vec), .out_val(out_val), .pull_dis(pull_dis),
    .drv_level(pad_out), .drv_en(pad_oe), .pull_en(pad_pull_en)
  );

  for (genvar i = 0; i < PINS; i++) begin : g_chk
    assert_input_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_vec[2*i +: 2] == PM_INPUT) |-> (!pad_oe[i] && !pad_out[i]));
    assert_pushpull_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_vec[2*i +: 2] == PM_PUSHPULL) |-> (pad_oe[i] && pad_out[i] == out_val[i]));
    assert_odrain_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_vec[2*i +: 2] == PM_ODRAIN && pad_oe[i]) |-> !pad_out[i]);
    assert_osource_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_vec[2*i +: 2] == PM_OSOURCE && pad_oe[i]) |-> pad_out[i]);
  end

  assert_pull_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(OFS_PULL)) |=> (pad_pull_en == ~$past(reg_wdata[PINS-1:0])));
endmodule

// File: tb/sim_gpio_port_ctrl.sv
module sim_gpio_port_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_out, pad_oe, pad_pull_en;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_mode = '0;
  logic [7:0]  m_data = '0;
  logic [7:0]  m_pull = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en)
  );

  function automatic logic [7:0] exp_oe(logic [15:0] md, logic [7:0] d);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      case (md[2*i +: 2])
        2'b01: r[i] = 1'b1;
        2'b10: r[i] = ~d[i];
        2'b11: r[i] = d[i];
        default: r[i] = 1'b0;
      endcase
    return r;
  endfunction

  function automatic logic [7:0] exp_out(logic [15:0] md, logic [7:0] d);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      case (md[2*i +: 2])
        2'b01: r[i] = d[i];
        2'b11: r[i] = 1'b1;
        default: r[i] = 1'b0;
      endcase
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk);
    if (a == 4'h0) m_mode = d[15:0];
    else if (a == 4'h4) m_data = d[7:0];
    else if (a == 4'h8) m_pull = d[7:0];
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic check_pads(string req);
    check({req, " oe"},   {24'h0, pad_oe},      {24'h0, exp_oe(m_mode, m_data)});
    check({req, " out"},  {24'h0, pad_out},     {24'h0, exp_out(m_mode, m_data)});
    check({req, " pull"}, {24'h0, pad_pull_en}, {24'h0, ~m_pull});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [3:0]  addrs [4];
    void'($urandom(32'd4711));
    addrs[0] = 4'h0; addrs[1] = 4'h4; addrs[2] = 4'h8; addrs[3] = 4'hC;

    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 oe in reset", {24'h0, pad_oe}, 32'h0);
    check("R1 out in reset", {24'h0, pad_out}, 32'h0);
    check("R1 pull in reset", {24'h0, pad_pull_en}, 32'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'h0, r); check("R1 mode after reset", r, 32'h0);
    rd(4'h8, r); check("R1 pull after reset", r, 32'h0);

    // R10: data written while in input mode, then enable push-pull
    wr(4'h4, 32'hFFFF_FFA5);
    check_pads("R6 input ignores data");
    wr(4'h0, 32'h0000_5555);
    check_pads("R10 data kept across mode change");
    check("R3 push-pull level", {24'h0, pad_out}, 32'hA5);
    wr(4'h0, 32'h0000_AAAA);
    check("R4 open-drain oe", {24'h0, pad_oe}, 32'h5A);
    check("R4 open-drain out", {24'h0, pad_out}, 32'h00);
    wr(4'h0, 32'hFFFF_FFFF);
    check("R5 open-source oe", {24'h0, pad_oe}, 32'hA5);
    check("R5 open-source out", {24'h0, pad_out}, 32'hFF);
    rd(4'h0, r); check("R2 mode upper bits", r, 32'h0000_FFFF);
    wr(4'h0, 32'hABCD_1B6C);
    rd(4'h0, r); check("R2 mode readback", r, 32'h0000_1B6C);
    check_pads("R2 mixed modes");

    wr(4'h8, 32'hFFFF_FF3C);
    check("R8 pull enable", {24'h0, pad_pull_en}, 32'hC3);
    rd(4'h8, r); check("R9 pull upper bits", r, 32'h0000_003C);

    wr(4'hC, 32'hFFFF_FFFF);
    check_pads("R9 unmapped write ignored");
    rd(4'h0, r); check("R9 mode untouched", r, 32'h0000_1B6C);
    rd(4'hC, r); check("R9 unmapped read", r, 32'h0);

    // R7: two-edge synchronizer latency
    @(negedge clk);
    pad_in = 8'h96;
    @(negedge clk);
    rd(4'h4, r); check("R7 after one edge", r, 32'h0);
    @(negedge clk);
    rd(4'h4, r); check("R7 after two edges", r, 32'h0000_0096);

    for (int n = 0; n < 300; n++) begin
      logic [3:0]  a;
      logic [31:0] d;
      a = addrs[$urandom_range(0, 3)];
      d = $urandom;
      pad_in = 8'($urandom);
      wr(a, d);
      check_pads("R3 R4 R5 R6 random");
      @(negedge clk);
      rd(4'h4, r); check("R7 random level", r, {24'h0, pad_in});
      rd(4'h0, r); check("R2 random readback", r, {16'h0, m_mode});
      rd(4'h8, r); check("R8 random readback", r, {24'h0, m_pull});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule